// File: doc/BRIEF.md
# Six-Section CIC Interpolator with Rate Select and Gain Correction

This block raises the sample rate of one signed DAC channel with a six-section cascaded integrator-comb filter. A 3-bit rate code picks the CIC upsampling factor at run time. The comb sections run at the input rate, each input sample is padded with zeros up to the factor, and the integrators run once per clock. The output is a stream at the DAC clock rate. The filter gain is factor to the fifth power. A fixed arithmetic right shift that depends on the rate removes most of that gain. The residual gain lies between 1.0 and 2.0, and an optional signed fixed-point multiply can cancel it. The result is rounded and clipped to the output width.

Codes with no filtered rate bypass the filter: each input sample reaches the output one cycle later. A suspend input holds the whole filter in its cleared state and stops sample requests. Changing the rate code restarts the filter from the cleared state.

Top module: `cic_interp`

## Requirements
- R1: The rate code sets the CIC factor R: 1 gives 5, 2 gives 50, 3 gives 500, 6 gives 5000 and 7 gives 50000. In these modes `in_ready` is high on the first cycle after start, then for exactly one cycle in every R cycles.
- R2: Codes 0, 4 and 5 bypass the filter. `in_ready` is high while not suspended, and `out_valid` and `out_data` equal the previous cycle's `in_valid` and `in_data`.
- R3: With correction off and a constant input x, the settled output is floor(x * R^5 / 2^S) clipped to the output width. S is 11, 28, 44, 61 and 78 for R = 5, 50, 500, 5000 and 50000.
- R4: With `corr_en` high, the settled output is floor((y * c + 2^13) / 2^14) clipped to the output width. Here y is the R3 value before clipping and c is `corr_coef` read as a signed 16-bit value with 14 fraction bits.
- R5: Every output is clipped to the signed range -2^(DW-1) to 2^(DW-1)-1 and never wraps.
- R6: In filtered mode the first `out_valid` appears 8 clock edges after the edge that takes the first sample, and carries floor(x0 / 2^S).
- R7: Once `out_valid` is high in filtered mode, it stays high on every cycle while the rate code is unchanged and suspend is low.
- R8: While `suspend` is high, `in_ready` is low and `out_valid` is low from the next cycle. All filter state is cleared, so after release the filter behaves as it does after reset.
- R9: A request cycle with `in_valid` low feeds a zero sample to the filter. After a run of such cycles the output settles to 0.
- R10: A change of the rate code clears the filter. `in_ready` is low in the cycle of the change and `out_valid` is low in the following cycle.
- R11: During reset, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | Holds the filter cleared and stops sample requests |
| rate_code | input | 3 | Rate select code |
| corr_en | input | 1 | Enables the gain-correction multiply |
| corr_coef | input | 16 | Signed correction coefficient, 14 fraction bits |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DW | Signed input sample |
| in_ready | output | 1 | Sample request, taken in this cycle |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DW | Signed output sample |

## Verification
A wrong rate counter shows up at `in_ready` within one request period, as a gap that is not R. A fault in an integrator, comb or shift corrupts the settled DC level, and it shows about 8·R cycles after a constant input starts. State that suspend or a rate change fails to clear shows as a nonzero first output after restart with a zero input, eight cycles after release. Rounding or clipping faults appear at once as a settled output that differs by one or has wrapped sign. The bench checks the pipeline depth by the exact cycle in which `out_valid` rises.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Codes that select a filtered rate
    function automatic logic code_filtered(input logic [2:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3) ||
               (code == 3'd6) || (code == 3'd7);
    endfunction

    // CIC upsampling factor per code (1 for bypass codes)
    function automatic int unsigned code_factor(input logic [2:0] code);
        case (code)
            3'd1:    return 5;
            3'd2:    return 50;
            3'd3:    return 500;
            3'd6:    return 5000;
            3'd7:    return 50000;
            default: return 1;
        endcase
    endfunction

    // floor(log2(factor^(sections-1))): the bit growth removed after the integrators
    function automatic int gain_shift(input int unsigned factor, input int sections);
        logic [127:0] prod;
        int msb;
        prod = 128'd1;
        for (int i = 0; i < sections - 1; i++) prod = prod * 128'(factor);
        msb = 0;
        for (int b = 0; b < 128; b++) if (prod[b]) msb = b;
        return msb;
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [CNT_W-1:0] period_m1,
    output logic             slot
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (hold)
            ctr_d.cnt = '0;
        else if (ctr_q.cnt == '0)
            ctr_d.cnt = period_m1;
        else
            ctr_d.cnt = ctr_q.cnt - CNT_W'(1);
        slot = !hold && (ctr_q.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int W = 112,
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         take,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    typedef struct packed {
        logic [N-1:0][W-1:0] dly;
    } cmb_t;

    cmb_t cmb_d, cmb_q;
    logic [W-1:0] stg [N+1];

    // Differences are formed in modular arithmetic; the wide word makes wrap harmless
    always_comb begin
        stg[0] = x;
        for (int k = 0; k < N; k++) stg[k+1] = stg[k] - cmb_q.dly[k];
        cmb_d = cmb_q;
        if (hold)
            cmb_d = '0;
        else if (take)
            for (int k = 0; k < N; k++) cmb_d.dly[k] = stg[k];
    end

    assign y = stg[N];

    always_ff @(posedge clk) begin
        if (rst) cmb_q <= '0;
        else     cmb_q <= cmb_d;
    end
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int W = 112,
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    typedef struct packed {
        logic [W-1:0]        feed;
        logic [N-1:0][W-1:0] acc;
    } int_t;

    int_t int_d, int_q;

    always_comb begin
        int_d = int_q;
        if (hold) begin
            int_d = '0;
        end else begin
            int_d.feed   = x;
            int_d.acc[0] = int_q.acc[0] + int_q.feed;
            for (int k = 1; k < N; k++) int_d.acc[k] = int_q.acc[k] + int_q.acc[k-1];
        end
    end

    assign y = int_q.acc[N-1];

    always_ff @(posedge clk) begin
        if (rst) int_q <= '0;
        else     int_q <= int_d;
    end
endmodule

// File: rtl/cic_gain_corr.sv
module cic_gain_corr #(
    parameter int DW   = 16,
    parameter int YW   = 18,
    parameter int CW   = 16,
    parameter int FRAC = 14
) (
    input  logic          en,
    input  logic [CW-1:0] coef,
    input  logic [YW-1:0] y,
    output logic [DW-1:0] z
);
    localparam int PW = YW + CW;
    localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] TOP_V = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] BOT_V = PW'(-(1 << (DW - 1)));

    logic signed [PW-1:0] ye, ce, prod, scaled, pick;

    always_comb begin
        ye     = PW'($signed(y));
        ce     = PW'($signed(coef));
        prod   = ye * ce;
        scaled = (prod + HALF) >>> FRAC;
        pick   = en ? scaled : ye;
        if (pick > TOP_V)
            z = TOP_V[DW-1:0];
        else if (pick < BOT_V)
            z = BOT_V[DW-1:0];
        else
            z = pick[DW-1:0];
    end
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
    parameter int DW           = 16,
    parameter int N_SECT       = 6,
    parameter int RMAX         = 50000,
    parameter int CW           = 16,
    parameter int CFRAC        = 14,
    parameter bit CORR_PRESENT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          suspend,
    input  logic [2:0]    rate_code,
    input  logic          corr_en,
    input  logic [CW-1:0] corr_coef,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int LOG_RMAX = $clog2(RMAX);
    localparam int ACC_W    = DW + N_SECT * LOG_RMAX;
    localparam int CNT_W    = LOG_RMAX;
    localparam int YW       = DW + 2;
    localparam int LIVE_W   = N_SECT + 1;
    localparam int SH_C1    = cic_pkg::gain_shift(cic_pkg::code_factor(3'd1), N_SECT);
    localparam int SH_C2    = cic_pkg::gain_shift(cic_pkg::code_factor(3'd2), N_SECT);
    localparam int SH_C3    = cic_pkg::gain_shift(cic_pkg::code_factor(3'd3), N_SECT);
    localparam int SH_C6    = cic_pkg::gain_shift(cic_pkg::code_factor(3'd6), N_SECT);
    localparam int SH_C7    = cic_pkg::gain_shift(cic_pkg::code_factor(3'd7), N_SECT);

    typedef struct packed {
        logic [2:0]        rate;
        logic [LIVE_W-1:0] live;
        logic              out_vld;
        logic [DW-1:0]     out_dat;
    } top_t;

    top_t top_d, top_q;

    logic             filt, flush, run, slot;
    logic [CNT_W-1:0] period_m1;
    logic [ACC_W-1:0] comb_x, comb_y, integ_x, integ_y;
    logic signed [ACC_W-1:0] acc_sh;
    logic [YW-1:0]    y_sh;
    logic [DW-1:0]    z_corr;
    int               sh;

    always_comb begin
        filt      = cic_pkg::code_filtered(rate_code);
        flush     = suspend || (rate_code != top_q.rate);
        run       = filt && !flush;
        period_m1 = CNT_W'(cic_pkg::code_factor(rate_code) - 1);
        in_ready  = filt ? slot : !flush;
        comb_x    = (slot && in_valid) ? ACC_W'($signed(in_data)) : '0;
        integ_x   = slot ? comb_y : '0;
        case (rate_code)
            3'd1:    sh = SH_C1;
            3'd2:    sh = SH_C2;
            3'd3:    sh = SH_C3;
            3'd6:    sh = SH_C6;
            3'd7:    sh = SH_C7;
            default: sh = 0;
        endcase
        acc_sh = $signed(integ_y) >>> sh;
        y_sh   = acc_sh[YW-1:0];
    end

    cic_rate_ctrl #(.CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst(rst), .hold(!run), .period_m1(period_m1), .slot(slot)
    );

    cic_comb_chain #(.W(ACC_W), .N(N_SECT)) u_comb (
        .clk(clk), .rst(rst), .hold(!run), .take(slot), .x(comb_x), .y(comb_y)
    );

    cic_integ_chain #(.W(ACC_W), .N(N_SECT)) u_integ (
        .clk(clk), .rst(rst), .hold(!run), .x(integ_x), .y(integ_y)
    );

    cic_gain_corr #(.DW(DW), .YW(YW), .CW(CW), .FRAC(CFRAC)) u_corr (
        .en(corr_en && CORR_PRESENT), .coef(corr_coef), .y(y_sh), .z(z_corr)
    );

    always_comb begin
        top_d      = top_q;
        top_d.rate = rate_code;
        if (flush) begin
            top_d.live    = '0;
            top_d.out_vld = 1'b0;
            top_d.out_dat = '0;
        end else if (filt) begin
            top_d.live    = {top_q.live[LIVE_W-2:0], 1'b1};
            top_d.out_vld = top_q.live[LIVE_W-1];
            top_d.out_dat = z_corr;
        end else begin
            top_d.live    = '0;
            top_d.out_vld = in_valid;
            if (in_valid) top_d.out_dat = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q      <= '0;
            top_q.rate <= rate_code;
        end else begin
            top_q <= top_d;
        end
    end

    assign out_valid = top_q.out_vld;
    assign out_data  = top_q.out_dat;
endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk (
    input logic       clk,
    input logic       rst,
    input logic       suspend,
    input logic [2:0] rate_code,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid
);
    // R1: a request in a filtered mode is never followed by another on the next cycle
    a_r1_ready_gap: assert property (@(posedge clk) disable iff (rst)
        (in_ready && cic_pkg::code_filtered(rate_code)) |=> !in_ready);

    // R2: bypass forwards valid with one cycle of delay
    a_r2_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !suspend && !cic_pkg::code_filtered(rate_code) &&
         rate_code == $past(rate_code)) |=> (out_valid == $past(in_valid)));

    // R7: filtered output stays valid while the configuration is steady
    a_r7_valid_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid && !suspend && cic_pkg::code_filtered(rate_code) &&
         rate_code == $past(rate_code)) |=> out_valid);

    // R8: suspend silences the output on the next cycle
    a_r8_suspend_quiet: assert property (@(posedge clk) disable iff (rst)
        suspend |=> !out_valid);
endmodule

bind cic_interp cic_interp_chk u_chk (
    .clk(clk), .rst(rst), .suspend(suspend), .rate_code(rate_code),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/cic_interp_test.sv
module cic_interp_test;
    logic        clk = 1'b0;
    logic        rst, suspend, corr_en, in_valid;
    logic [2:0]  rate_code;
    logic [15:0] corr_coef, in_data;
    logic        in_ready, out_valid;
    logic [15:0] out_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    cic_interp uut (
        .clk(clk), .rst(rst), .suspend(suspend), .rate_code(rate_code),
        .corr_en(corr_en), .corr_coef(corr_coef), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data)
    );

    typedef struct packed {
        logic [2:0]         code;
        logic signed [31:0] x;
        logic               en;
        logic signed [31:0] coef;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd1,   1000, 1'b0,      0},
        '{3'd1,  -1000, 1'b0,      0},
        '{3'd2,  12345, 1'b0,      0},
        '{3'd3,  -7000, 1'b0,      0},
        '{3'd1,   1000, 1'b1,  10700},
        '{3'd2, -20000, 1'b1,  14027},
        '{3'd1,  20000, 1'b1,  32767},
        '{3'd1, -20000, 1'b1,  32767},
        '{3'd3,  32767, 1'b0,      0},
        '{3'd1,   5000, 1'b1, -16384}
    };

    function automatic longint fac_of(input int c);
        case (c)
            1: return 5;
            2: return 50;
            3: return 500;
            6: return 5000;
            7: return 50000;
            default: return 1;
        endcase
    endfunction

    function automatic int sh_of(input int c);
        case (c)
            1: return 11;
            2: return 28;
            3: return 44;
            6: return 61;
            7: return 78;
            default: return 0;
        endcase
    endfunction

    function automatic longint clip16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint expect_dc(input int c, input longint x, input bit en, input longint coef);
        longint p, y;
        p = 1;
        for (int i = 0; i < 5; i++) p = p * fac_of(c);
        y = (x * p) >>> sh_of(c);
        if (en) y = (y * coef + 8192) >>> 14;
        return clip16(y);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start(input logic [2:0] c, input logic en, input int coef, input int x, input logic v);
        @(negedge clk);
        suspend   = 1'b1;
        rate_code = c;
        corr_en   = en;
        corr_coef = 16'(coef);
        in_valid  = 1'b0;
        @(negedge clk);
        suspend  = 1'b0;
        in_valid = v;
        in_data  = 16'(x);
    endtask

    task automatic gap_test(input logic [2:0] c);
        int n;
        start(c, 1'b0, 0, 0, 1'b1);
        #1;
        chk($sformatf("R1 first request code %0d", c), longint'(in_ready), 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!in_ready && n < fac_of(c) + 3);
        chk($sformatf("R1 request gap code %0d", c), n, fac_of(c));
    endtask

    task automatic run_all();
        longint exp;
        int drops;
        logic [15:0] pd;
        logic pv;

        // R11: reset state
        rst = 1'b1; suspend = 1'b0; rate_code = 3'd1; corr_en = 1'b0;
        corr_coef = '0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        chk("R11 out_valid in reset", longint'(out_valid), 0);
        chk("R11 out_data in reset", longint'($signed(out_data)), 0);
        rst = 1'b0;

        // R3 R4 R5: settled DC levels from the vector table
        for (int i = 0; i < 10; i++) begin
            string tag;
            start(VECS[i].code, VECS[i].en, int'(VECS[i].coef), int'(VECS[i].x), 1'b1);
            repeat (8 * fac_of(int'(VECS[i].code)) + 20) @(negedge clk);
            exp = expect_dc(int'(VECS[i].code), longint'(VECS[i].x), VECS[i].en, longint'(VECS[i].coef));
            tag = VECS[i].en ? "R4" : "R3";
            if (exp == 32767 || exp == -32768) tag = {tag, " R5"};
            chk($sformatf("%s dc vector %0d level", tag, i), longint'($signed(out_data)), exp);
            chk($sformatf("R7 dc vector %0d valid", i), longint'(out_valid), 1);
        end

        // R6: first output timing and value; R7: no gaps afterwards
        start(3'd1, 1'b0, 0, 20000, 1'b1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 7) chk("R6 out_valid before latency", longint'(out_valid), 0);
            if (k == 8) begin
                chk("R6 out_valid at latency", longint'(out_valid), 1);
                chk("R6 first output value", longint'($signed(out_data)), longint'(20000) >>> 11);
            end
        end
        drops = 0;
        repeat (40) begin
            @(negedge clk);
            if (!out_valid) drops++;
        end
        chk("R7 valid drops while steady", drops, 0);

        // R1: request cadence per code
        gap_test(3'd1);
        gap_test(3'd2);
        gap_test(3'd6);
        gap_test(3'd7);

        // R2: bypass for codes 0 and 5
        for (int m = 0; m < 2; m++) begin
            start(m == 0 ? 3'd0 : 3'd5, 1'b0, 0, 0, 1'b0);
            #1;
            chk("R2 bypass ready", longint'(in_ready), 1);
            pv = 1'b0;
            pd = '0;
            for (int i = 0; i < 6; i++) begin
                in_valid = (i != 2);
                in_data  = 16'(100 * i - 250);
                pv = in_valid;
                pd = in_data;
                @(negedge clk);
                chk("R2 bypass valid", longint'(out_valid), longint'(pv));
                if (pv) chk("R2 bypass data", longint'($signed(out_data)), longint'($signed(pd)));
            end
        end

        // R8: suspend clears everything
        start(3'd1, 1'b0, 0, 1000, 1'b1);
        repeat (60) @(negedge clk);
        chk("R3 level before suspend", longint'($signed(out_data)), expect_dc(1, 1000, 1'b0, 0));
        suspend = 1'b1;
        @(negedge clk);
        chk("R8 out_valid under suspend", longint'(out_valid), 0);
        chk("R8 in_ready under suspend", longint'(in_ready), 0);
        in_data = '0;
        suspend = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 valid after release", longint'(out_valid), 1);
        chk("R8 cleared state after release", longint'($signed(out_data)), 0);

        // R9: missing samples become zeros
        start(3'd1, 1'b0, 0, 1000, 1'b1);
        repeat (60) @(negedge clk);
        in_valid = 1'b0;
        repeat (60) @(negedge clk);
        chk("R9 output after underrun", longint'($signed(out_data)), 0);
        chk("R9 valid during underrun", longint'(out_valid), 1);

        // R10: a rate change restarts the filter
        in_valid  = 1'b1;
        rate_code = 3'd2;
        #1;
        chk("R10 in_ready at rate change", longint'(in_ready), 0);
        @(negedge clk);
        chk("R10 out_valid after rate change", longint'(out_valid), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog expired before all checks ran");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule